// File: doc/BRIEF.md
# Dual-Mode PWM Timebase with Shadow Reload

This block is the timing core of a three-channel pulse-width modulator. A 16-bit counter advances on a clock enable derived from the input clock by a selectable power-of-two divider. In edge-aligned mode it counts up to the active period value and wraps to zero. In center-aligned mode it counts up to the period and back down to zero, which forms a triangle. Each channel compares the counter against its own active duty value and produces one raw compare output. A global inversion bit and a grouping bit shape the three outputs: with grouping set, all three channels take the duty of channel 0.

The period and duty values are written into shadow registers, and the active copies stay untouched until software arms a load. The armed load lands at one well-defined point of the count: the wrap point in edge-aligned mode, and either the bottom or the peak of the triangle in center-aligned mode. A period-event flag, cleared by writing one, is raised once every 1+N selected counter events and can drive an interrupt line.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset the counter is 0, period_flag, irq and load_pending are 0, the active period and all active duties are 0, and every cmp_out bit is 0.
- R2: In edge-aligned mode (center_mode=0), each tick moves the counter from value c to c+1 while c is below the active period P; at c>=P the counter wraps to 0, which is a match event. The count cycle is P+1 ticks long.
- R3: In center-aligned mode (center_mode=1), the counter rises 0,1,...,P and then falls P-1,...,0, for a cycle of 2P ticks. A tick that leaves P while counting up is a match event. A tick that leaves 0 while counting down is an underflow event.
- R4: div_sel=d gives one tick every 2^d clock cycles while run=1. The first tick falls on the 2^d-th rising edge that samples run=1.
- R5: While run=0 (and clr_req=0), the counter holds its value.
- R6: A cycle with clr_req=1 sets the counter to 0 and the direction to up, and restarts the event divider. This overrides any tick in that cycle.
- R7: per_wr and duty_wr[i] write wdata into shadow registers only. load_req=1 sets load_pending from the next cycle on. The active period and duties take the shadow values at the first reload point after that, and load_pending falls in the same edge. In edge-aligned mode the reload point is the match event.
- R8: In center-aligned mode, cen_reload=0 places the reload point at the underflow event and cen_reload=1 places it at the match event (the peak).
- R9: The period event is the match event in edge-aligned mode. In center-aligned mode it is the underflow event when evt_sel=0 and the match event when evt_sel=1. period_flag sets on every (1+evt_div)-th period event counted since the last clear.
- R10: flag_clr=1 clears period_flag in the next cycle unless a flag-setting event happens in the same cycle. irq is high exactly when period_flag=1 and irq_en=1.
- R11: cmp_out[i] equals (counter < effective duty of channel i) XOR invert. Duty 0 gives a constant low and a duty above P gives a constant high (before inversion).
- R12: With group=1, every channel uses the active duty of channel 0, so all cmp_out bits are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter runs when high |
| div_sel | input | 2 | Tick divider: 1, 2, 4 or 8 clocks per tick |
| center_mode | input | 1 | 0 edge-aligned, 1 center-aligned |
| cen_reload | input | 1 | Center mode reload point: 0 bottom, 1 peak |
| evt_sel | input | 1 | Center mode period event: 0 underflow, 1 match |
| evt_div | input | 4 | Flag raised every evt_div+1 events |
| irq_en | input | 1 | Lets period_flag drive irq |
| invert | input | 1 | Inverts all compare outputs |
| group | input | 1 | All channels use duty of channel 0 |
| clr_req | input | 1 | Clear counter pulse |
| load_req | input | 1 | Arm shadow-to-active transfer |
| flag_clr | input | 1 | Write-one clear of period_flag |
| per_wr | input | 1 | Write wdata into shadow period |
| duty_wr | input | 3 | Write wdata into shadow duty of channel i |
| wdata | input | 16 | Shadow write data |
| cnt | output | 16 | Counter value |
| cmp_out | output | 3 | Per-channel compare outputs |
| load_pending | output | 1 | Armed transfer not yet done |
| period_flag | output | 1 | Period-event flag |
| irq | output | 1 | Gated period interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, three channels, a 2-bit divider select and a 4-bit event divider. It uses short periods of 3 to 6 so that every combination of alignment mode, all four divider settings, inversion, grouping and event source can be swept across several full count cycles. Counter, compare and flag values are checked against closed-form formulas at every tick. Directed runs place armed reloads against the wrap, bottom and peak points and confirm the cycle in which the new period and duty appear. They also cover stop, clear and the write-one flag clear.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic match;
        logic under;
    } cnt_evt_t;

    function automatic logic pick_reload(input logic center, input logic at_peak,
                                         input cnt_evt_t ev);
        if (!center) return ev.match;
        return at_peak ? ev.match : ev.under;
    endfunction

    function automatic logic pick_period_evt(input logic center, input logic on_match,
                                             input cnt_evt_t ev);
        if (!center) return ev.match;
        return on_match ? ev.match : ev.under;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PS_W = (1 << DIV_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    always_comb mask = (PS_W'(1) << div_sel) - PS_W'(1);

    assign tick = run && ((ps_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) ps_q <= '0;
        else             ps_q <= ps_q + PS_W'(1);
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic             center,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt,
    output cnt_evt_t         ev
);
    logic [CNT_W-1:0] cnt_n;
    dir_e             dir_q, dir_n;

    always_comb begin
        cnt_n = cnt;
        dir_n = dir_q;
        ev    = '0;
        if (tick) begin
            if (!center) begin
                if (cnt >= per) begin
                    cnt_n    = '0;
                    dir_n    = DIR_UP;
                    ev.match = 1'b1;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end else if (dir_q == DIR_UP) begin
                if (cnt >= per) begin
                    ev.match = 1'b1;
                    dir_n    = DIR_DOWN;
                    cnt_n    = (cnt == '0) ? '0 : cnt - CNT_W'(1);
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end else begin
                if (cnt == '0) begin
                    ev.under = 1'b1;
                    dir_n    = DIR_UP;
                    cnt_n    = (per == '0) ? '0 : CNT_W'(1);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
        end
        if (clr) begin
            cnt_n = '0;
            dir_n = DIR_UP;
            ev    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt   <= cnt_n;
            dir_q <= dir_n;
        end
    end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      per_wr,
    input  logic [NCH-1:0]            duty_wr,
    input  logic [CNT_W-1:0]          wdata,
    input  logic                      load_req,
    input  logic                      reload_pt,
    output logic [CNT_W-1:0]          per_act,
    output logic [NCH-1:0][CNT_W-1:0] duty_act,
    output logic                      pending
);
    logic [CNT_W-1:0]          per_sh;
    logic [NCH-1:0][CNT_W-1:0] duty_sh;
    logic                      do_load;

    assign do_load = pending && reload_pt;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_sh  <= '0;
            per_act <= '0;
            pending <= 1'b0;
        end else begin
            if (per_wr)  per_sh  <= wdata;
            if (do_load) per_act <= per_sh;
            pending <= load_req ? 1'b1 : (do_load ? 1'b0 : pending);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst) begin
                duty_sh[i]  <= '0;
                duty_act[i] <= '0;
            end else begin
                if (duty_wr[i]) duty_sh[i]  <= wdata;
                if (do_load)    duty_act[i] <= duty_sh[i];
            end
        end
    end
endmodule

// File: rtl/pwm_evt_flag.sv
module pwm_evt_flag #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             restart,
    input  logic             flag_clr,
    input  logic [EVT_W-1:0] evt_div,
    output logic             flag
);
    logic [EVT_W-1:0] ecnt_q;
    logic             last;

    assign last = evt && !restart && (ecnt_q >= evt_div);

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt_q <= '0;
            flag   <= 1'b0;
        end else begin
            if (restart)   ecnt_q <= '0;
            else if (evt)  ecnt_q <= (ecnt_q >= evt_div) ? '0 : ecnt_q + EVT_W'(1);
            if (last)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input  logic [CNT_W-1:0]          cnt,
    input  logic [NCH-1:0][CNT_W-1:0] duty,
    input  logic                      invert,
    input  logic                      group,
    output logic [NCH-1:0]            out
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CNT_W-1:0] d_eff;
        assign d_eff  = group ? duty[0] : duty[i];
        assign out[i] = (cnt < d_eff) ^ invert;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 3,
    parameter int DIV_W = 2,
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             center_mode,
    input  logic             cen_reload,
    input  logic             evt_sel,
    input  logic [EVT_W-1:0] evt_div,
    input  logic             irq_en,
    input  logic             invert,
    input  logic             group,
    input  logic             clr_req,
    input  logic             load_req,
    input  logic             flag_clr,
    input  logic             per_wr,
    input  logic [NCH-1:0]   duty_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [NCH-1:0]   cmp_out,
    output logic             load_pending,
    output logic             period_flag,
    output logic             irq
);
    logic                      tick;
    cnt_evt_t                  ev;
    logic [CNT_W-1:0]          per_act;
    logic [NCH-1:0][CNT_W-1:0] duty_act;
    logic                      reload_pt;
    logic                      period_evt;

    assign reload_pt  = pick_reload(center_mode, cen_reload, ev);
    assign period_evt = pick_period_evt(center_mode, evt_sel, ev);
    assign irq        = period_flag && irq_en;

    pwm_prescaler #(.DIV_W(DIV_W)) u_ps (
        .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clr(clr_req), .center(center_mode),
        .per(per_act), .cnt(cnt), .ev(ev)
    );

    pwm_shadow #(.CNT_W(CNT_W), .NCH(NCH)) u_sh (
        .clk(clk), .rst(rst), .per_wr(per_wr), .duty_wr(duty_wr), .wdata(wdata),
        .load_req(load_req), .reload_pt(reload_pt), .per_act(per_act),
        .duty_act(duty_act), .pending(load_pending)
    );

    pwm_evt_flag #(.EVT_W(EVT_W)) u_flag (
        .clk(clk), .rst(rst), .evt(period_evt), .restart(clr_req),
        .flag_clr(flag_clr), .evt_div(evt_div), .flag(period_flag)
    );

    pwm_compare #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
        .cnt(cnt), .duty(duty_act), .invert(invert), .group(group), .out(cmp_out)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             clr_req,
    input logic             load_req,
    input logic             load_pending,
    input logic             center_mode,
    input logic             group,
    input logic             tick,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] cnt,
    input logic [NCH-1:0]   cmp_out,
    input logic             period_flag
);
    // R5
    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr_req) |=> $stable(cnt));

    // R6
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (cnt == '0));

    // R7
    a_r7_load_arms: assert property (@(posedge clk) disable iff (rst)
        load_req |=> load_pending);

    // R2
    a_r2_edge_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !center_mode && !clr_req && (cnt < per_act)) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R9
    a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(period_flag) |-> $past(tick));

    // R12
    a_r12_group_equal: assert property (@(posedge clk) disable iff (rst)
        group |-> (cmp_out == '0 || cmp_out == '1));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .run(run), .clr_req(clr_req), .load_req(load_req),
    .load_pending(load_pending), .center_mode(center_mode), .group(group),
    .tick(tick), .per_act(per_act), .cnt(cnt), .cmp_out(cmp_out),
    .period_flag(period_flag)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst;
    logic        run, center_mode, cen_reload, evt_sel, irq_en, invert, group;
    logic        clr_req, load_req, flag_clr, per_wr;
    logic [1:0]  div_sel;
    logic [3:0]  evt_div;
    logic [2:0]  duty_wr;
    logic [15:0] wdata;
    logic [15:0] cnt;
    logic [2:0]  cmp_out;
    logic        load_pending, period_flag, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_timebase dut (
        .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .center_mode(center_mode),
        .cen_reload(cen_reload), .evt_sel(evt_sel), .evt_div(evt_div), .irq_en(irq_en),
        .invert(invert), .group(group), .clr_req(clr_req), .load_req(load_req),
        .flag_clr(flag_clr), .per_wr(per_wr), .duty_wr(duty_wr), .wdata(wdata),
        .cnt(cnt), .cmp_out(cmp_out), .load_pending(load_pending),
        .period_flag(period_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_cnt(int t, int p, bit c);
        int m;
        if (!c) return t % (p + 1);
        m = t % (2 * p);
        return (m <= p) ? m : 2 * p - m;
    endfunction

    function automatic int exp_events(int t, int p, bit c, bit sel);
        if (!c) return t / (p + 1);
        if (sel) return (t + p - 1) / (2 * p);
        return (t == 0) ? 0 : (t - 1) / (2 * p);
    endfunction

    task automatic program_regs(input int p, input int d0, input int d1, input int d2);
        run = 0; center_mode = 0; div_sel = 0;
        clr_req = 1; step(); clr_req = 0;
        wdata = 16'(p); per_wr = 1; step(); per_wr = 0;
        wdata = 16'(d0); duty_wr = 3'b001; step();
        wdata = 16'(d1); duty_wr = 3'b010; step();
        wdata = 16'(d2); duty_wr = 3'b100; step(); duty_wr = 0;
        load_req = 1; step(); load_req = 0;
        run = 1;
        for (int k = 0; k < 300 && load_pending; k++) step();
        run = 0;
        clr_req = 1; flag_clr = 1; step(); clr_req = 0; flag_clr = 0;
    endtask

    task automatic write_shadow(input int p, input int d0);
        wdata = 16'(p); per_wr = 1; step(); per_wr = 0;
        wdata = 16'(d0); duty_wr = 3'b001; step(); duty_wr = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; run = 0; center_mode = 0; cen_reload = 0; evt_sel = 0; irq_en = 0;
        invert = 0; group = 0; clr_req = 0; load_req = 0; flag_clr = 0; per_wr = 0;
        div_sel = 0; evt_div = 0; duty_wr = 0; wdata = 0;
        step(); step();
        rst = 0;
        step();

        // R1 reset state
        chk("R1 cnt", int'(cnt), 0);
        chk("R1 flag", int'(period_flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 pending", int'(load_pending), 0);
        chk("R1 cmp", int'(cmp_out), 0);

        // Sweep: R2 R3 R4 R9 R10 R11 R12
        for (int c = 0; c < 2; c++)
            for (int d = 0; d < 4; d++)
                for (int iv = 0; iv < 2; iv++)
                    for (int g = 0; g < 2; g++) begin
                        int p;
                        int dv[3];
                        int jmax;
                        p = 3 + d;
                        dv[0] = 2; dv[1] = 0; dv[2] = p + 1;
                        program_regs(p, dv[0], dv[1], dv[2]);
                        center_mode = c[0]; div_sel = 2'(d); invert = iv[0]; group = g[0];
                        evt_sel = iv[0]; evt_div = 4'(d); irq_en = g[0]; cen_reload = 0;
                        run = 1;
                        jmax = (4 * p + 3) << d;
                        for (int j = 1; j <= jmax; j++) begin
                            int t, ec, ev, fl;
                            step();
                            t  = j >> d;
                            ec = exp_cnt(t, p, c[0]);
                            ev = exp_events(t, p, c[0], iv[0]);
                            fl = (ev >= d + 1) ? 1 : 0;
                            chk(c ? "R3 R4 cnt" : "R2 R4 cnt", int'(cnt), ec);
                            chk("R9 flag", int'(period_flag), fl);
                            chk("R10 irq", int'(irq), fl & g);
                            for (int i = 0; i < 3; i++) begin
                                int de;
                                de = g ? dv[0] : dv[i];
                                chk("R11 cmp", int'(cmp_out[i]), ((ec < de) ? 1 : 0) ^ iv);
                            end
                            if (g) chk("R12 group", int'(cmp_out[2] == cmp_out[0]), 1);
                        end
                        run = 0;
                    end
        invert = 0; group = 0; evt_sel = 0; irq_en = 0; evt_div = 0;

        // R5 stop holds counter, R6 clear
        program_regs(5, 3, 3, 3);
        run = 1; step(); step(); step();
        chk("R5 cnt before stop", int'(cnt), 3);
        run = 0;
        for (int k = 0; k < 4; k++) step();
        chk("R5 cnt held", int'(cnt), 3);
        run = 1; step();
        chk("R5 resumes", int'(cnt), 4);
        clr_req = 1; step(); clr_req = 0;
        chk("R6 cleared", int'(cnt), 0);
        step();
        chk("R6 counts after clear", int'(cnt), 1);
        run = 0;

        // R7 edge-aligned reload at wrap
        program_regs(5, 3, 3, 3);
        write_shadow(2, 1);
        chk("R7 no load without request", int'(load_pending), 0);
        run = 1;
        for (int t = 1; t <= 7; t++) begin
            step();
            chk("R7 shadow ignored", int'(cnt), t % 6);
        end
        chk("R7 old duty kept", int'(cmp_out[0]), 1);
        run = 0;
        program_regs(5, 3, 3, 3);
        write_shadow(2, 1);
        load_req = 1; step(); load_req = 0;
        chk("R7 pending armed", int'(load_pending), 1);
        run = 1;
        step(); step();
        chk("R7 old duty", int'(cmp_out[0]), 1);
        step(); step(); step();
        chk("R7 cnt at old peak", int'(cnt), 5);
        chk("R7 pending at peak", int'(load_pending), 1);
        step();
        chk("R7 wrap", int'(cnt), 0);
        chk("R7 pending cleared", int'(load_pending), 0);
        step(); step();
        chk("R7 new period cnt", int'(cnt), 2);
        chk("R7 new duty", int'(cmp_out[0]), 0);
        step();
        chk("R7 new wrap", int'(cnt), 0);
        chk("R7 new duty high", int'(cmp_out[0]), 1);
        run = 0;

        // R8 center reload at bottom
        program_regs(4, 2, 2, 2);
        center_mode = 1; cen_reload = 0;
        write_shadow(2, 1);
        load_req = 1; step(); load_req = 0;
        run = 1;
        for (int k = 0; k < 8; k++) step();
        chk("R8 bottom cnt", int'(cnt), 0);
        chk("R8 bottom pending", int'(load_pending), 1);
        chk("R8 bottom old duty", int'(cmp_out[0]), 1);
        step();
        chk("R8 bottom reloaded", int'(load_pending), 0);
        chk("R8 bottom cnt up", int'(cnt), 1);
        step();
        chk("R8 bottom new peak", int'(cnt), 2);
        chk("R8 bottom new duty", int'(cmp_out[0]), 0);
        step(); step();
        chk("R8 bottom new cycle", int'(cnt), 0);
        run = 0;

        // R8 center reload at peak
        program_regs(4, 2, 2, 2);
        center_mode = 1; cen_reload = 1;
        write_shadow(2, 1);
        load_req = 1; step(); load_req = 0;
        run = 1;
        for (int k = 0; k < 4; k++) step();
        chk("R8 peak cnt", int'(cnt), 4);
        chk("R8 peak pending", int'(load_pending), 1);
        step();
        chk("R8 peak reloaded", int'(load_pending), 0);
        chk("R8 peak descend", int'(cnt), 3);
        step(); step(); step();
        chk("R8 peak bottom", int'(cnt), 0);
        chk("R8 peak new duty", int'(cmp_out[0]), 1);
        step(); step();
        chk("R8 peak new period", int'(cnt), 2);
        step();
        chk("R8 peak falls", int'(cnt), 1);
        run = 0; cen_reload = 0;

        // R10 write-one clear and repeat
        program_regs(2, 0, 0, 0);
        evt_div = 1; irq_en = 1;
        run = 1;
        for (int k = 0; k < 5; k++) step();
        chk("R10 flag not yet", int'(period_flag), 0);
        step();
        chk("R10 flag set", int'(period_flag), 1);
        chk("R10 irq set", int'(irq), 1);
        flag_clr = 1; step(); flag_clr = 0;
        chk("R10 flag cleared", int'(period_flag), 0);
        for (int k = 0; k < 4; k++) step();
        chk("R10 flag waits", int'(period_flag), 0);
        step();
        chk("R10 flag again", int'(period_flag), 1);
        run = 0;
        irq_en = 0; #1;
        chk("R10 irq masked", int'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule